// File: doc/BRIEF.md
# Table-Driven Reloadable State Machine

This block is a sequencer whose whole transition graph lives in a writable lookup table instead of fixed gates. On every run clock the machine inputs and the current state together form a table address. The word stored there supplies the output value and the next state. A transition graph of any complexity therefore costs the same logic, and is limited only by the number of inputs, states and outputs. With the default parameters there are 4 inputs, 16 states and 4 outputs. The table then needs words of outputs plus ceil(log2 states) bits, which is 8 bits, and 2^(inputs + ceil(log2 states)) entries, which is 256.

A parameter selects the timing variant. In the Moore variant the inputs are captured in a register before they reach the table, and the outputs are registered along with the state. In the Mealy variant the live inputs address the table, only the state is registered, and the outputs follow the inputs within the same cycle.

Raising the reconfigure input switches the table's lookup address over to a load port and enables writes, one entry per clock. While the load runs, the sequencer stays frozen. When reconfigure drops, the machine continues from the state it held, using the new contents. The rest of the system keeps running throughout.

Top module: `lut_state_machine`

Phases of the control process: RESET (reset high: clear the state), LOAD (reconfigure high: hold the state, write the table), STEP (normal run: take the table's next state). Transitions: any phase goes to RESET while reset is high. RESET or STEP goes to LOAD when reconfigure rises. LOAD goes to STEP when reconfigure falls.

## Requirements
- R1: With reset high at a clock edge, the state becomes 0 after that edge. In the Moore variant the output also becomes 0, and so does the input register.
- R2: The lookup address is {machine inputs, current state}, with the inputs in the upper 4 bits. A table word is {outputs, next state}, with the outputs in the upper 4 bits.
- R3: Moore variant: each edge loads the input register from mach_in. Each run edge loads state_q from the next-state field, and mach_out from the output field, of the entry at {input register, state_q}. A change on mach_in therefore affects state_q two edges later.
- R4: Mealy variant: each run edge loads state_q from the next-state field of the entry at {mach_in, state_q}. mach_out shows the output field of that entry combinationally.
- R5: While reconf is high and reset is low, state_q holds its value, and the Moore mach_out holds as well. Each edge writes ld_data into the entry at ld_addr.
- R6: While reconf is high, the lookup address is ld_addr. In the Mealy variant, mach_out shows the output field of that entry as it stands before the edge's write.
- R7: After reconf falls, the next run edge steps from the held state using the newly written contents.
- R8: With a suitable table, state 0 with input 0 steps to state 1, and state 1 with input 5 steps to state 5.
- R9: Reset takes priority over reconf: no table write happens on an edge with reset high, and the state is cleared.
- R10: A write changes only the entry at ld_addr. Every other entry keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reconf | input | 1 | High: load the table and freeze the sequencer |
| mach_in | input | IN_W (4) | Machine inputs |
| ld_addr | input | IN_W+ST_W (8) | Table entry address used during a load |
| ld_data | input | OUT_W+ST_W (8) | Word written during a load |
| mach_out | output | OUT_W (4) | Machine outputs |
| state_q | output | ST_W (4) | Current state |

## Verification
Assertions check several rules on every cycle. The state must freeze during a load, and in the Moore variant the output must freeze too. On every run edge, the state must take the next-state field that the table presented in the previous cycle, and the Moore output must take the output field. Other behaviours can only be shown by the bench's scenarios, run on a Moore and a Mealy instance side by side:
- that the nibble order of the address and the word is correct;
- the two-edge input latency of the Moore variant;
- the lookup address during a load, seen on the Mealy output;
- that a write touches only its own entry;
- that reset blocks writes;
- the example transitions 0→1 and 1→5.

// File: rtl/lsm_pkg.sv
`timescale 1ns/1ps
package lsm_pkg;

    // Sequencer control phases
    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_LOAD  = 2'd1,
        PH_STEP  = 2'd2
    } phase_t;

    // Bits needed to encode n distinct values (at least one)
    function automatic int unsigned bits_for(input int unsigned n);
        int unsigned w;
        w = 1;
        for (int i = 1; i < 31; i++) begin
            if ((32'd1 << i) < n) w = i + 1;
        end
        return w;
    endfunction

    // Table word width: outputs plus encoded state
    function automatic int unsigned word_bits(input int unsigned n_out, input int unsigned n_states);
        return n_out + bits_for(n_states);
    endfunction

    // Table entry count: two to the power of inputs plus encoded state
    function automatic int unsigned entry_count(input int unsigned n_in, input int unsigned n_states);
        return 32'd1 << (n_in + bits_for(n_states));
    endfunction

endpackage

// File: rtl/lsm_addr_sel.sv
`timescale 1ns/1ps
module lsm_addr_sel #(
    parameter int IN_W = 4,
    parameter int ST_W = 4,
    localparam int ADDR_W = IN_W + ST_W
) (
    input  logic              reconf,
    input  logic [IN_W-1:0]   run_in,
    input  logic [ST_W-1:0]   cur_st,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] rd_addr
);

    logic [ADDR_W-1:0] run_addr;

    // Inputs in the upper field, state in the lower field
    assign run_addr = {run_in, cur_st};

    always_comb begin
        if (reconf) rd_addr = ld_addr;
        else        rd_addr = run_addr;
    end

endmodule

// File: rtl/lsm_table.sv
`timescale 1ns/1ps
module lsm_table #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] entry_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) entry_q[wr_addr] <= wr_data;
    end

    assign rd_word = entry_q[rd_addr];

endmodule

// File: rtl/lsm_seq.sv
`timescale 1ns/1ps
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int IN_W  = 4,
    parameter int ST_W  = 4,
    parameter int OUT_W = 4,
    parameter bit MEALY = 1'b0,
    localparam int WORD_W = OUT_W + ST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reconf,
    input  logic [IN_W-1:0]   mach_in,
    input  logic [WORD_W-1:0] tbl_word,
    output logic [IN_W-1:0]   run_in,
    output logic [ST_W-1:0]   cur_st,
    output logic [OUT_W-1:0]  mach_out,
    output logic              tbl_we
);

    phase_t            phase;
    logic [ST_W-1:0]   nxt_field;
    logic [OUT_W-1:0]  out_field;

    assign nxt_field = tbl_word[ST_W-1:0];
    assign out_field = tbl_word[WORD_W-1:ST_W];

    // Phase decode: reset wins over load, load wins over step
    always_comb begin
        if (rst)         phase = PH_RESET;
        else if (reconf) phase = PH_LOAD;
        else             phase = PH_STEP;
    end

    assign tbl_we = (phase == PH_LOAD);

    // State register
    always_ff @(posedge clk) begin
        unique case (phase)
            PH_RESET: cur_st <= '0;
            PH_LOAD:  cur_st <= cur_st;
            PH_STEP:  cur_st <= nxt_field;
            default:  cur_st <= '0;
        endcase
    end

    generate
        if (MEALY == 1'b0) begin : g_moore
            logic [IN_W-1:0]  in_q;
            logic [OUT_W-1:0] out_q;

            // Registered inputs feed the lookup
            always_ff @(posedge clk) begin
                if (rst) in_q <= '0;
                else     in_q <= mach_in;
            end

            // Registered outputs move with the state
            always_ff @(posedge clk) begin
                unique case (phase)
                    PH_RESET: out_q <= '0;
                    PH_LOAD:  out_q <= out_q;
                    PH_STEP:  out_q <= out_field;
                    default:  out_q <= '0;
                endcase
            end

            assign run_in   = in_q;
            assign mach_out = out_q;
        end else begin : g_mealy
            // Live inputs address the table; outputs follow combinationally
            assign run_in   = mach_in;
            assign mach_out = out_field;
        end
    endgenerate

endmodule

// File: rtl/lut_state_machine.sv
`timescale 1ns/1ps
module lut_state_machine #(
    parameter int IN_W     = 4,
    parameter int N_STATES = 16,
    parameter int OUT_W    = 4,
    parameter bit MEALY    = 1'b0,
    localparam int ST_W    = lsm_pkg::bits_for(N_STATES),
    localparam int WORD_W  = lsm_pkg::word_bits(OUT_W, N_STATES),
    localparam int DEPTH   = lsm_pkg::entry_count(IN_W, N_STATES),
    localparam int ADDR_W  = IN_W + ST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reconf,
    input  logic [IN_W-1:0]   mach_in,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic [OUT_W-1:0]  mach_out,
    output logic [ST_W-1:0]   state_q
);

    logic [IN_W-1:0]   run_in;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] tbl_word;
    logic              tbl_we;

    lsm_addr_sel #(
        .IN_W (IN_W),
        .ST_W (ST_W)
    ) u_addr (
        .reconf  (reconf),
        .run_in  (run_in),
        .cur_st  (state_q),
        .ld_addr (ld_addr),
        .rd_addr (rd_addr)
    );

    lsm_table #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_tbl (
        .clk     (clk),
        .wr_en   (tbl_we),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (rd_addr),
        .rd_word (tbl_word)
    );

    lsm_seq #(
        .IN_W  (IN_W),
        .ST_W  (ST_W),
        .OUT_W (OUT_W),
        .MEALY (MEALY)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .reconf   (reconf),
        .mach_in  (mach_in),
        .tbl_word (tbl_word),
        .run_in   (run_in),
        .cur_st   (state_q),
        .mach_out (mach_out),
        .tbl_we   (tbl_we)
    );

endmodule

// File: rtl/lsm_checker.sv
`timescale 1ns/1ps
module lsm_checker #(
    parameter int ST_W   = 4,
    parameter int OUT_W  = 4,
    parameter int WORD_W = 8,
    parameter bit MEALY  = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              reconf,
    input logic [ST_W-1:0]   state_q,
    input logic [OUT_W-1:0]  mach_out,
    input logic [WORD_W-1:0] tbl_word
);

    // R5: state frozen across a load edge
    p_hold_state_r5: assert property (@(posedge clk) disable iff (rst)
        reconf |=> state_q == $past(state_q));

    // R5: Moore output frozen across a load edge
    p_hold_out_r5: assert property (@(posedge clk) disable iff (rst)
        (reconf && MEALY == 1'b0) |=> mach_out == $past(mach_out));

    // R3 R4: run edge takes the next-state field presented by the table
    p_step_next_r3: assert property (@(posedge clk) disable iff (rst)
        !reconf |=> state_q == $past(tbl_word[ST_W-1:0]));

    // R3: Moore output takes the output field on a run edge
    p_moore_out_r3: assert property (@(posedge clk) disable iff (rst)
        (!reconf && MEALY == 1'b0) |=> mach_out == $past(tbl_word[WORD_W-1:ST_W]));

endmodule

bind lut_state_machine lsm_checker #(
    .ST_W   (ST_W),
    .OUT_W  (OUT_W),
    .WORD_W (WORD_W),
    .MEALY  (MEALY)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reconf   (reconf),
    .state_q  (state_q),
    .mach_out (mach_out),
    .tbl_word (tbl_word)
);

// File: tb/lut_state_machine_tb_top.sv
`timescale 1ns/1ps
module lut_state_machine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reconf = 1'b0;
    logic [3:0] mach_in = '0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [3:0] out_a, st_a, out_b, st_b;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [7:0] m_tbl [256];
    logic [3:0] m_inq = '0, m_st_a = '0, m_out_a = '0, m_st_b = '0;

    always #2.5 clk = ~clk;

    lut_state_machine #(.MEALY(1'b0)) dut_i (
        .clk(clk), .rst(rst), .reconf(reconf), .mach_in(mach_in),
        .ld_addr(ld_addr), .ld_data(ld_data), .mach_out(out_a), .state_q(st_a));

    lut_state_machine #(.MEALY(1'b1)) dut_mealy_i (
        .clk(clk), .rst(rst), .reconf(reconf), .mach_in(mach_in),
        .ld_addr(ld_addr), .ld_data(ld_data), .mach_out(out_b), .state_q(st_b));

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock edge, with the model advanced per the requirements
    task automatic tick();
        logic [7:0] wa, wb;
        wa = m_tbl[{m_inq, m_st_a}];
        wb = m_tbl[{mach_in, m_st_b}];
        @(posedge clk);
        #1;
        if (rst) begin
            m_st_a = '0; m_out_a = '0; m_inq = '0; m_st_b = '0;
        end else begin
            if (reconf) m_tbl[ld_addr] = ld_data;
            else begin
                m_st_a = wa[3:0]; m_out_a = wa[7:4]; m_st_b = wb[3:0];
            end
            m_inq = mach_in;
        end
    endtask

    task automatic check_all(input string req);
        logic [7:0] eb;
        eb = reconf ? m_tbl[ld_addr] : m_tbl[{mach_in, m_st_b}];
        chk(req, "moore state", {4'h0, st_a}, {4'h0, m_st_a});
        chk(req, "moore out", {4'h0, out_a}, {4'h0, m_out_a});
        chk(req, "mealy state", {4'h0, st_b}, {4'h0, m_st_b});
        chk(req, "mealy out", {4'h0, out_b}, {4'h0, eb[7:4]});
    endtask

    function automatic logic [7:0] pat(input logic [7:0] a, input logic [3:0] seed);
        logic [3:0] nx, o;
        nx = a[3:0] * 4'd3 + a[7:4] + seed;
        o  = a[7:4] ^ a[3:0] ^ seed;
        if (a == 8'h00) return 8'h01;   // state 0, input 0 -> state 1
        if (a == 8'h51) return 8'h45;   // state 1, input 5 -> state 5
        return {o, nx};
    endfunction

    task automatic t_reset();
        rst = 1'b1; reconf = 1'b0; mach_in = 4'h9;
        tick(); tick();
        chk("R1", "moore state", {4'h0, st_a}, 8'h00);
        chk("R1", "moore out", {4'h0, out_a}, 8'h00);
        chk("R1", "mealy state", {4'h0, st_b}, 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_load(input logic [3:0] seed, input bit chk_mealy);
        reconf = 1'b1;
        for (int a = 0; a < 256; a++) begin
            ld_addr = 8'(a);
            ld_data = pat(8'(a), seed);
            mach_in = 4'(a * 5);
            #1;
            if (chk_mealy) begin
                logic [7:0] old;
                old = m_tbl[8'(a)];
                chk("R6", "mealy out at load addr", {4'h0, out_b}, {4'h0, old[7:4]});
            end
            tick();
            check_all("R5");
        end
        reconf = 1'b0;
        #1;
    endtask

    task automatic t_example();
        rst = 1'b1; mach_in = 4'h0;
        tick();
        rst = 1'b0;
        tick();
        chk("R8", "mealy 0 in 0", {4'h0, st_b}, 8'h01);
        chk("R8", "moore 0 in 0", {4'h0, st_a}, 8'h01);
        mach_in = 4'h5;
        #1;
        chk("R8", "mealy out state1 in5", {4'h0, out_b}, 8'h04);
        tick();
        chk("R8", "mealy 1 in 5", {4'h0, st_b}, 8'h05);
        check_all("R3 R8");
    endtask

    task automatic t_walk(input int seed, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            mach_in = 4'((i * 7 + seed) % 16);
            #1;
            check_all(req);
            tick();
            check_all(req);
        end
    endtask

    task automatic t_reload_mid();
        logic [7:0] pa, pb;
        mach_in = 4'h3;
        tick(); tick();
        reconf = 1'b1;
        pa = {m_inq, m_st_a};
        ld_addr = pa; ld_data = 8'hA7;
        tick();
        check_all("R7");
        pb = {mach_in, m_st_b};
        ld_addr = pb; ld_data = 8'h3C;
        tick();
        check_all("R7");
        reconf = 1'b0;
        #1;
        tick();
        check_all("R7");
        if (pa != pb) chk("R7", "moore new entry", {4'h0, st_a}, 8'h07);
        chk("R7", "mealy new entry", {4'h0, st_b}, 8'h0C);
    endtask

    task automatic t_reset_prio();
        rst = 1'b1; reconf = 1'b1; ld_addr = 8'h00; ld_data = 8'hFF;
        tick();
        reconf = 1'b0;
        tick();
        chk("R9", "state after reset with load", {4'h0, st_b}, 8'h00);
        rst = 1'b0; mach_in = 4'h0;
        #1;
        chk("R9", "entry 00 out unchanged", {4'h0, out_b}, 8'h00);
        tick();
        chk("R9", "entry 00 next unchanged", {4'h0, st_b}, 8'h01);
        check_all("R9");
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_load(4'h1, 1'b0);
        t_example();
        t_walk(3, 40, "R2 R3 R4");
        t_load(4'h6, 1'b1);
        t_walk(11, 40, "R2 R3 R4");
        t_reload_mid();
        t_walk(5, 30, "R10");
        t_reset_prio();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule